// File: doc/BRIEF.md
# SPI Master Burst Engine

This block is the data path of an SPI master. Software configures the word width and the number of words in a burst, loads transmit words into a small FIFO, then sets a start bit. The engine asserts the select line, shifts each word out most significant bit first while capturing the return line into a receive FIFO, releases select after a short guard time, and raises a completion flag that can drive an interrupt.

The serial clock runs at a fixed ratio to the system clock set by the parameter `HALF` (system cycles per half serial period). Mode 0 timing is used: the clock idles low, output bits change on the falling edge and input bits are captured on the rising edge. Three enable outputs tell the pad ring whether to drive clock, data out and select. They are always on during a burst and, if software asks, also while idle.

Register map (2-bit word address): 0 = data (write pushes TX, read pops RX), 1 = control, 2 = status, 3 = maintenance. Control: bits [4:0] word bits minus one (reset 7), bits [8+:AW] burst words minus one, bit 16 start (write-only), bit 20 data-out drive, bit 21 clock drive, bit 22 select drive, bit 24 completion interrupt enable. Status: bit 0 done, bit 1 RX not empty, bit 2 RX at least half full, bit 3 RX full, bit 4 TX empty, bit 5 TX full, bit 6 busy. Maintenance: bit 0 write-1 FIFO flush.

Top module: `spi_burst_master`

## Requirements
- R1: After reset select is high, clock and data out are low, all drive enables and the interrupt are low, and status reads 0x10 (only TX empty).
- R2: The burst field holds the word count minus one; a burst produces exactly (field+1)×(word bits) rising clock edges.
- R3: A burst moves at most `DEPTH` words; a burst field value above `DEPTH`-1 is stored and read back as `DEPTH`-1.
- R4: Writing 1 to control bit 16 while idle starts a burst; no burst starts without it, and writing it while busy has no effect.
- R5: Status bit 0 is set when select is released at the end of a burst and cleared by writing 1 to status bit 0 (writing 0 leaves it); the interrupt is high exactly when that bit and control bit 24 are both set.
- R6: Status bits report RX not empty (bit 1), RX count ×2 ≥ `DEPTH` (bit 2), RX full (bit 3), TX empty (bit 4), TX full (bit 5) and busy (bit 6).
- R7: Words leave most significant bit first; data out changes on falling clock edges, data in is captured on rising edges, and each received word is right-aligned with zero upper bits.
- R8: Control bits [4:0] set the word width as bits minus one; widths of 8, 16 and 32 bits work.
- R9: Select stays low for the whole burst and rises exactly two `HALF` periods (one serial clock period) after the last falling clock edge; the clock only toggles while select is low.
- R10: Control bits 20, 21, 22 drive the data-out, clock and select enable outputs while idle; during a burst all three are high.
- R11: Writing 1 to maintenance bit 0 empties both FIFOs.
- R12: A write to a full TX FIFO is dropped; reading an empty RX FIFO returns the last word popped and leaves the FIFO empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX on address 0) |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Completion interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low select |
| sclk_oe | output | 1 | Drive enable for the clock pad |
| mosi_oe | output | 1 | Drive enable for the data-out pad |
| ss_oe | output | 1 | Drive enable for the select pad |

## Verification
A wrong bit or word counter shows at once as a wrong number of clock edges per burst and a select release at the wrong time, measured against the last falling edge. A broken shift register or FIFO pointer shows as loopback data that does not match what was pushed, visible at the first RX read after the burst. FIFO count errors surface in the status bits right after the pushes or the burst that caused them, and in dropped or duplicated words when the full or empty limit is reached.

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int DEPTH = 16,
  parameter int HALF  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        ss_n,
  output logic        sclk_oe,
  output logic        mosi_oe,
  output logic        ss_oe
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int HW = (HALF > 1) ? $clog2(2 * HALF) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  typedef enum logic [1:0] {IDLE, RUN, TAIL} state_t;

  state_t      state;
  logic [4:0]  len_m1;
  logic [AW-1:0] burst_m1;
  logic        oe_mosi, oe_sclk, oe_ss, tc_en, tc_q;
  logic [HW-1:0] hc;
  logic        sclk_q, ss_q;
  logic [4:0]  bit_cnt;
  logic [AW-1:0] word_cnt;
  logic [31:0] sh, rsh;

  logic [31:0] tx_mem [DEPTH];
  logic [31:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_rp, tx_wp, rx_rp, rx_wp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [31:0] rx_last;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  wire busy      = state != IDLE;
  wire wr_data   = reg_wr && reg_addr == 2'd0;
  wire wr_ctrl   = reg_wr && reg_addr == 2'd1;
  wire wr_stat   = reg_wr && reg_addr == 2'd2;
  wire flush     = reg_wr && reg_addr == 2'd3 && reg_wdata[0];
  wire start     = wr_ctrl && reg_wdata[16] && !busy;
  wire half_end  = hc == HW'(HALF - 1);
  wire tail_end  = hc == HW'(2 * HALF - 1);
  wire fall_evt  = state == RUN && half_end && sclk_q;
  wire word_done = fall_evt && bit_cnt == len_m1;
  wire last_word = word_done && word_cnt == burst_m1;
  wire load_word = start || (word_done && !last_word);
  wire tx_full   = tx_cnt == CW'(DEPTH);
  wire tx_empty  = tx_cnt == '0;
  wire rx_full   = rx_cnt == CW'(DEPTH);
  wire rx_empty  = rx_cnt == '0;
  wire rx_half   = ({1'b0, rx_cnt} << 1) >= (CW + 1)'(DEPTH);
  wire tx_push   = wr_data && !tx_full;
  wire tx_pop    = load_word && !tx_empty;
  wire rx_push   = word_done && !rx_full;
  wire rx_pop    = reg_rd && reg_addr == 2'd0 && !rx_empty;
  wire [31:0] tx_head = tx_empty ? 32'd0 : tx_mem[tx_rp];
  wire [AW-1:0] burst_in = reg_wdata[8 +: AW];

  always_ff @(posedge clk) if (tx_push) tx_mem[tx_wp] <= reg_wdata;
  always_ff @(posedge clk) if (rx_push) rx_mem[rx_wp] <= rsh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
    end else if (flush) begin
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= nxt(tx_wp);
      if (tx_pop)  tx_rp <= nxt(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0; rx_last <= '0;
    end else if (flush) begin
      rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= nxt(rx_wp);
      if (rx_pop) begin
        rx_rp   <= nxt(rx_rp);
        rx_last <= rx_mem[rx_rp];
      end
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      len_m1 <= 5'd7; burst_m1 <= '0;
      oe_mosi <= 1'b0; oe_sclk <= 1'b0; oe_ss <= 1'b0; tc_en <= 1'b0;
    end else if (wr_ctrl) begin
      oe_mosi <= reg_wdata[20];
      oe_sclk <= reg_wdata[21];
      oe_ss   <= reg_wdata[22];
      tc_en   <= reg_wdata[24];
      if (!busy) begin
        len_m1   <= reg_wdata[4:0];
        burst_m1 <= (burst_in > LAST) ? LAST : burst_in;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tc_q <= 1'b0;
    else if (state == TAIL && tail_end) tc_q <= 1'b1;
    else if (wr_stat && reg_wdata[0]) tc_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= IDLE; hc <= '0; sclk_q <= 1'b0; ss_q <= 1'b1;
      bit_cnt <= '0; word_cnt <= '0; sh <= '0; rsh <= '0;
    end else begin
      unique case (state)
        IDLE: if (start) begin
          state <= RUN; hc <= '0; sclk_q <= 1'b0; ss_q <= 1'b0;
          bit_cnt <= '0; word_cnt <= '0; sh <= tx_head; rsh <= '0;
        end
        RUN: if (half_end) begin
          hc <= '0;
          sclk_q <= !sclk_q;
          if (!sclk_q) rsh <= {rsh[30:0], miso};
          else if (last_word) state <= TAIL;
          else if (word_done) begin
            bit_cnt <= '0; word_cnt <= word_cnt + 1'b1;
            sh <= tx_head; rsh <= '0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            sh <= sh << 1;
          end
        end else hc <= hc + 1'b1;
        TAIL: if (tail_end) begin
          state <= IDLE; hc <= '0; ss_q <= 1'b1;
        end else hc <= hc + 1'b1;
        default: state <= IDLE;
      endcase
    end

  assign sclk    = sclk_q;
  assign ss_n    = ss_q;
  assign mosi    = (state == RUN) ? sh[len_m1] : 1'b0;
  assign sclk_oe = busy | oe_sclk;
  assign mosi_oe = busy | oe_mosi;
  assign ss_oe   = busy | oe_ss;
  assign irq     = tc_q & tc_en;

  always_comb begin
    unique case (reg_addr)
      2'd0: reg_rdata = rx_empty ? rx_last : rx_mem[rx_rp];
      2'd1: begin
        reg_rdata = '0;
        reg_rdata[4:0]    = len_m1;
        reg_rdata[8 +: AW] = burst_m1;
        reg_rdata[20] = oe_mosi;
        reg_rdata[21] = oe_sclk;
        reg_rdata[22] = oe_ss;
        reg_rdata[24] = tc_en;
      end
      2'd2: reg_rdata = {25'd0, busy, tx_full, tx_empty, rx_full, rx_half, !rx_empty, tc_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

module spi_burst_master_chk #(
  parameter int DEPTH = 16
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic ss_n,
  input logic tc,
  input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
  input logic [$clog2(DEPTH+1)-1:0] rx_cnt
);
  localparam int CW = $clog2(DEPTH + 1);

  assert_tx_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));
  assert_rx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));
  assert_sclk_low_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !sclk);
  assert_toggle_selected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> !ss_n);
  assert_done_on_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |-> tc);
endmodule

bind spi_burst_master spi_burst_master_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .tc(tc_q),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/test_spi_burst_master.sv
module test_spi_burst_master;
  localparam int DEPTH = 15;
  localparam int HALF  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, sclk, mosi, miso, ss_n, sclk_oe, mosi_oe, ss_oe;
  logic inv = 1'b0;

  int n_chk = 0, n_fail = 0, rise_cnt = 0;
  time t_fall = 0, t_ssr = 0;
  logic [31:0] cap = '0;
  logic [4:0] c_len = 5'd7;
  logic [3:0] c_burst = '0;
  logic [2:0] c_oe = '0;
  logic c_en = 1'b0;

  assign miso = mosi ^ inv;
  always #5 clk = ~clk;

  spi_burst_master #(.DEPTH(DEPTH), .HALF(HALF)) i_spi_burst_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sclk(sclk), .mosi(mosi),
    .miso(miso), .ss_n(ss_n), .sclk_oe(sclk_oe), .mosi_oe(mosi_oe), .ss_oe(ss_oe));

  always @(posedge sclk) begin rise_cnt <= rise_cnt + 1; cap <= {cap[30:0], mosi}; end
  always @(negedge sclk) t_fall = $time;
  always @(posedge ss_n) t_ssr = $time;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic set_ctrl(input bit exch);
    logic [31:0] w;
    w = '0;
    w[4:0] = c_len; w[11:8] = c_burst; w[16] = exch;
    w[22:20] = c_oe; w[24] = c_en;
    wr(2'd1, w);
  endtask

  task automatic run_burst();
    rise_cnt = 0;
    wr(2'd2, 32'd1);
    set_ctrl(1'b1);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (ss_n) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(ss_n === 1'b1 && sclk === 1'b0 && mosi === 1'b0, "R1 lines", {ss_n, sclk, mosi}, 3'b100);
    check({sclk_oe, mosi_oe, ss_oe, irq} === 4'b0, "R1 enables", {sclk_oe, mosi_oe, ss_oe, irq}, 0);
    rd(2'd2, d); check(d === 32'h10, "R1 status", d, 32'h10);
  endtask

  task automatic t_word8();
    logic [31:0] d;
    logic [31:0] w [3] = '{32'h1A5, 32'h3C, 32'h81};
    inv = 1'b0; c_len = 5'd7; c_burst = 4'd2;
    for (int i = 0; i < 3; i++) wr(2'd0, w[i]);
    run_burst();
    check(rise_cnt == 24, "R2 edges 3x8", rise_cnt, 24);
    check(cap[7:0] === 8'h81, "R7 msb first", cap[7:0], 8'h81);
    for (int i = 0; i < 3; i++) begin
      rd(2'd0, d); check(d === (w[i] & 32'hFF), "R8 8-bit loopback", d, w[i] & 32'hFF);
    end
  endtask

  task automatic t_word16();
    logic [31:0] d;
    logic [31:0] w [2] = '{32'h1234, 32'hBEEF};
    inv = 1'b1; c_len = 5'd15; c_burst = 4'd1;
    for (int i = 0; i < 2; i++) wr(2'd0, w[i]);
    run_burst();
    check(rise_cnt == 32, "R2 edges 2x16", rise_cnt, 32);
    for (int i = 0; i < 2; i++) begin
      rd(2'd0, d); check(d === (~w[i] & 32'hFFFF), "R7 16-bit inverted capture", d, ~w[i] & 32'hFFFF);
    end
    inv = 1'b0;
  endtask

  task automatic t_word32();
    logic [31:0] d;
    c_len = 5'd31; c_burst = 4'd0;
    wr(2'd0, 32'hDEADBEEF);
    run_burst();
    check(rise_cnt == 32, "R8 edges 1x32", rise_cnt, 32);
    rd(2'd0, d); check(d === 32'hDEADBEEF, "R8 32-bit loopback", d, 32'hDEADBEEF);
  endtask

  task automatic t_done_irq();
    logic [31:0] d;
    c_len = 5'd7; c_burst = 4'd0; c_en = 1'b0;
    wr(2'd0, 32'h11);
    run_burst();
    rd(2'd0, d);
    rd(2'd2, d); check(d[0] === 1'b1, "R5 done set", d[0], 1);
    check(irq === 1'b0, "R5 irq masked", irq, 0);
    c_en = 1'b1; set_ctrl(1'b0);
    @(negedge clk); check(irq === 1'b1, "R5 irq enabled", irq, 1);
    wr(2'd2, 32'd0);
    rd(2'd2, d); check(d[0] === 1'b1, "R5 write 0 keeps", d[0], 1);
    wr(2'd2, 32'd1);
    rd(2'd2, d); check(d[0] === 1'b0 && irq === 1'b0, "R5 write 1 clears", {d[0], irq}, 0);
    c_en = 1'b0; set_ctrl(1'b0);
  endtask

  task automatic t_select();
    logic [31:0] d;
    c_len = 5'd7; c_burst = 4'd1;
    wr(2'd0, 32'h55); wr(2'd0, 32'hAA);
    rise_cnt = 0;
    wr(2'd2, 32'd1);
    set_ctrl(1'b1);
    repeat (20) @(negedge clk);
    check(ss_n === 1'b0, "R9 select held mid-burst", ss_n, 0);
    check({sclk_oe, mosi_oe, ss_oe} === 3'b111, "R10 enables during burst", {sclk_oe, mosi_oe, ss_oe}, 3'b111);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (ss_n) break;
    end
    check(t_ssr - t_fall == 2 * HALF * 10, "R9 release gap", t_ssr - t_fall, 2 * HALF * 10);
    rd(2'd0, d); rd(2'd0, d);
    check(d === 32'hAA, "R7 second word", d, 32'hAA);
  endtask

  task automatic t_cap_full();
    logic [31:0] d;
    c_len = 5'd7; c_burst = 4'd15;
    set_ctrl(1'b0);
    rd(2'd1, d); check(d[11:8] === 4'd14, "R3 burst clamp", d[11:8], 14);
    c_burst = 4'd14;
    for (int i = 0; i < DEPTH; i++) wr(2'd0, 32'h10 + i);
    rd(2'd2, d); check(d[5] === 1'b1, "R6 tx full", d[5], 1);
    wr(2'd0, 32'h99);
    run_burst();
    check(rise_cnt == DEPTH * 8, "R3 depth-limited burst", rise_cnt, DEPTH * 8);
    rd(2'd2, d); check(d[6:1] === 6'b001111, "R6 rx half full ready, tx empty", d[6:1], 6'b001111);
    for (int i = 0; i < DEPTH; i++) begin
      rd(2'd0, d); check(d === 32'h10 + i, "R12 full push dropped", d, 32'h10 + i);
    end
    rd(2'd0, d); check(d === 32'h1E, "R12 empty read repeats", d, 32'h1E);
    rd(2'd0, d); check(d === 32'h1E, "R12 empty read repeats again", d, 32'h1E);
    rd(2'd2, d); check(d[3:1] === 3'b000, "R12 rx stays empty", d[3:1], 0);
  endtask

  task automatic t_start_busy();
    logic [31:0] d;
    c_len = 5'd7; c_burst = 4'd0;
    wr(2'd0, 32'h5A);
    rise_cnt = 0;
    repeat (10) @(negedge clk);
    check(ss_n === 1'b1 && rise_cnt == 0, "R4 no start without bit", rise_cnt, 0);
    wr(2'd0, 32'h6B);
    set_ctrl(1'b1);
    set_ctrl(1'b1);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (ss_n) break;
    end
    repeat (60) @(negedge clk);
    check(rise_cnt == 8 && ss_n === 1'b1, "R4 start while busy ignored", rise_cnt, 8);
    rd(2'd2, d); check(d[4] === 1'b0, "R4 second word still queued", d[4], 0);
    rd(2'd0, d); check(d === 32'h5A, "R4 first word", d, 32'h5A);
  endtask

  task automatic t_flush();
    logic [31:0] d;
    c_len = 5'd7; c_burst = 4'd0;
    run_burst();
    wr(2'd0, 32'h1); wr(2'd0, 32'h2);
    rd(2'd2, d); check(d[4] === 1'b0 && d[1] === 1'b1, "R11 before flush", d[4:1], 4'b0001);
    wr(2'd3, 32'd1);
    rd(2'd2, d); check(d[5:1] === 5'b01000, "R11 both fifos empty", d[5:1], 5'b01000);
  endtask

  task automatic t_oe();
    c_oe = 3'b111; set_ctrl(1'b0);
    @(negedge clk);
    check({sclk_oe, mosi_oe, ss_oe} === 3'b111 && ss_n === 1'b1 && sclk === 1'b0,
          "R10 idle drive on", {sclk_oe, mosi_oe, ss_oe}, 3'b111);
    c_oe = 3'b010; set_ctrl(1'b0);
    @(negedge clk);
    check({mosi_oe, sclk_oe, ss_oe} === 3'b010, "R10 clock drive only", {mosi_oe, sclk_oe, ss_oe}, 3'b010);
    c_oe = 3'b000; set_ctrl(1'b0);
    @(negedge clk);
    check({sclk_oe, mosi_oe, ss_oe} === 3'b000, "R10 idle release", {sclk_oe, mosi_oe, ss_oe}, 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word8();
    t_word16();
    t_word32();
    t_done_irq();
    t_select();
    t_cap_full();
    t_start_busy();
    t_flush();
    t_oe();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule